// File: doc/BRIEF.md
# Selectable-Ratio Synthesizer Divider Pair

This block holds the digital dividers of a frequency synthesizer loop. A loop counter, clocked by the prescaled oscillator clock, divides by a programmable scaling factor and emits the feedback comparison pulse. A reference counter, clocked by the crystal clock, divides by a ratio chosen from a small code table and emits the reference comparison pulse. The two pulses go to a phase comparator outside this block. The locked oscillator frequency is 16 × scaling factor × reference clock / reference ratio. The factor 16 comes from the external prescaler.

The ratio table depends on the control bus in use. With the two-wire bus a 3-bit code selects one of seven ratios, and one code stops the reference counter. With the three-wire bus two code bits and a bank level input select one of eight ratios, and the scaling factor narrows to 14 bits. A scaling factor of zero stops the loop counter. A test enable copies both pulses onto two port pins.

Each counter counts down and picks up its ratio only when it reloads, so a ratio change never shortens a period. All control inputs are quasi-static: they change rarely and are not synchronised. This interface carries no data stream, so every pin is a plain level.

Top module: `pll_divider_pair`

## Requirements
- R1: With `wire3_mode`=0, `fp_pulse` rises once every `scale_factor` cycles of `vco_clk`, for every factor from 256 to 32767.
- R2: With `wire3_mode`=1, bit 14 of `scale_factor` is ignored, and the loop period is `scale_factor[13:0]` cycles.
- R3: When the effective scaling factor is zero, `fp_pulse` stays low.
- R4: With `wire3_mode`=0, `ratio_code` selects the following reference periods in `ref_clk` cycles: 0 gives 1024, 2 gives 256, 3 gives 512, 4 gives 140, 5 gives 25, 6 gives 250 and 7 gives 50.
- R5: With `wire3_mode`=0 and `ratio_code`=1, the reference counter is stopped and `fr_pulse` stays low. When a valid code returns, counting resumes with the new ratio.
- R6: With `wire3_mode`=1 and `ref_bank_hi`=0, `ratio_code[1:0]` selects a period of 280 for 0, 50 for 1, 500 for 2 and 100 for 3. `ratio_code[2]` is ignored.
- R7: With `wire3_mode`=1 and `ref_bank_hi`=1, `ratio_code[1:0]` selects a period of 140 for 0, 25 for 1, 250 for 2 and 50 for 3.
- R8: Each pulse on `fp_pulse` and on `fr_pulse` lasts exactly one cycle of its own clock.
- R9: A ratio change takes effect only at the next reload. The interval that is running when the change arrives completes with the old ratio, and the next interval uses the new one.
- R10: With `div_test_en`=1, `test_pin_fp` and `test_pin_fr` copy `fp_pulse` and `fr_pulse`. With `div_test_en`=0, both test pins stay low.
- R11: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Prescaled oscillator clock for the loop counter |
| ref_clk | input | 1 | Crystal reference clock for the reference counter |
| rst_n | input | 1 | Asynchronous active-low reset for both counters |
| scale_factor | input | 15 | Loop scaling factor |
| ratio_code | input | 3 | Reference ratio select code |
| wire3_mode | input | 1 | 1 selects the three-wire bus tables and the 14-bit factor |
| ref_bank_hi | input | 1 | Bank level for the three-wire ratio table |
| div_test_en | input | 1 | Routes both pulses onto the test pins |
| fp_pulse | output | 1 | Loop-divider comparison pulse (vco_clk domain) |
| fr_pulse | output | 1 | Reference-divider comparison pulse (ref_clk domain) |
| test_pin_fp | output | 1 | Test copy of fp_pulse |
| test_pin_fr | output | 1 | Test copy of fr_pulse |

## Verification
Some properties are checked on every cycle:
- every pulse is one cycle wide;
- the stop code and a zero factor keep their pulse low;
- the test pins stay quiet while test is disabled;
- reset forces the outputs low.

The exact periods cannot be seen cycle by cycle. These are the values of every table entry, the dropped factor bit in three-wire mode, the one-interval delay before a new ratio takes effect, and the restart after the stop code. Bench scenarios measure them as intervals between pulses and compare them with a table the bench computes itself.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  localparam int SF_WIDTH_DEF  = 15;
  localparam int REF_WIDTH_DEF = 11;
  localparam int CODE_WIDTH    = 3;

  typedef enum logic {
    BUS_TWO_WIRE   = 1'b0,
    BUS_THREE_WIRE = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic                     stop;
    logic [REF_WIDTH_DEF-1:0] ratio;
  } ref_sel_t;

endpackage

// File: rtl/pd_ratio_decode.sv
module pd_ratio_decode
  import pll_div_pkg::*;
#(
  parameter int RW = REF_WIDTH_DEF
) (
  input  logic [CODE_WIDTH-1:0] code,
  input  bus_mode_e             mode,
  input  logic                  bank_hi,
  output logic [RW-1:0]         ratio,
  output logic                  stop
);

  logic [RW-1:0] two_wire_ratio;
  logic [RW-1:0] three_wire_ratio;
  logic          two_wire_stop;

  // Two-wire table: one code is the stop state
  always_comb begin
    two_wire_stop = 1'b0;
    unique case (code)
      3'd0: two_wire_ratio = RW'(1024);
      3'd1: begin
        two_wire_ratio = '0;
        two_wire_stop  = 1'b1;
      end
      3'd2: two_wire_ratio = RW'(256);
      3'd3: two_wire_ratio = RW'(512);
      3'd4: two_wire_ratio = RW'(140);
      3'd5: two_wire_ratio = RW'(25);
      3'd6: two_wire_ratio = RW'(250);
      default: two_wire_ratio = RW'(50);
    endcase
  end

  // Three-wire table: bank level plus the two low code bits
  always_comb begin
    unique case ({bank_hi, code[1:0]})
      3'b000: three_wire_ratio = RW'(280);
      3'b001: three_wire_ratio = RW'(50);
      3'b010: three_wire_ratio = RW'(500);
      3'b011: three_wire_ratio = RW'(100);
      3'b100: three_wire_ratio = RW'(140);
      3'b101: three_wire_ratio = RW'(25);
      3'b110: three_wire_ratio = RW'(250);
      default: three_wire_ratio = RW'(50);
    endcase
  end

  always_comb begin
    if (mode == BUS_THREE_WIRE) begin
      ratio = three_wire_ratio;
      stop  = 1'b0;
    end else begin
      ratio = two_wire_ratio;
      stop  = two_wire_stop;
    end
  end

endmodule

// File: rtl/pd_sf_select.sv
module pd_sf_select
  import pll_div_pkg::*;
#(
  parameter int SW = SF_WIDTH_DEF
) (
  input  bus_mode_e     mode,
  input  logic [SW-1:0] sf_in,
  output logic [SW-1:0] sf_eff
);

  localparam int NARROW_W = SW - 1;

  // Three-wire mode carries one bit fewer; the top bit is forced to zero
  always_comb begin
    if (mode == BUS_THREE_WIRE) sf_eff = {1'b0, sf_in[NARROW_W-1:0]};
    else                        sf_eff = sf_in;
  end

endmodule

// File: rtl/pd_downcount.sv
module pd_downcount #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] ratio,
  output logic         pulse
);

  logic [W-1:0] cnt_q;
  logic         halt;
  logic         at_end;

  assign halt   = hold || (ratio == '0);
  assign at_end = (cnt_q == '0);

  // Ratio is sampled only on reload, so a change never cuts a period short
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (halt) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (at_end) begin
      cnt_q <= ratio - 1'b1;
      pulse <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/pll_divider_pair.sv
module pll_divider_pair
  import pll_div_pkg::*;
#(
  parameter int SF_W  = SF_WIDTH_DEF,
  parameter int REF_W = REF_WIDTH_DEF
) (
  input  logic                  vco_clk,
  input  logic                  ref_clk,
  input  logic                  rst_n,
  input  logic [SF_W-1:0]       scale_factor,
  input  logic [CODE_WIDTH-1:0] ratio_code,
  input  logic                  wire3_mode,
  input  logic                  ref_bank_hi,
  input  logic                  div_test_en,
  output logic                  fp_pulse,
  output logic                  fr_pulse,
  output logic                  test_pin_fp,
  output logic                  test_pin_fr
);

  bus_mode_e          mode;
  logic [SF_W-1:0]    sf_eff;
  logic [REF_W-1:0]   ref_ratio;
  logic               ref_stop;

  assign mode = wire3_mode ? BUS_THREE_WIRE : BUS_TWO_WIRE;

  pd_sf_select #(.SW(SF_W)) u_sf_select (
    .mode   (mode),
    .sf_in  (scale_factor),
    .sf_eff (sf_eff)
  );

  pd_ratio_decode #(.RW(REF_W)) u_ratio_decode (
    .code    (ratio_code),
    .mode    (mode),
    .bank_hi (ref_bank_hi),
    .ratio   (ref_ratio),
    .stop    (ref_stop)
  );

  pd_downcount #(.W(SF_W)) u_loop_count (
    .clk   (vco_clk),
    .rst_n (rst_n),
    .hold  (1'b0),
    .ratio (sf_eff),
    .pulse (fp_pulse)
  );

  pd_downcount #(.W(REF_W)) u_ref_count (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .hold  (ref_stop),
    .ratio (ref_ratio),
    .pulse (fr_pulse)
  );

  assign test_pin_fp = div_test_en & fp_pulse;
  assign test_pin_fr = div_test_en & fr_pulse;

endmodule

// File: rtl/pll_divider_pair_chk.sv
module pll_divider_pair_chk #(
  parameter int SF_W = 15
) (
  input logic            vco_clk,
  input logic            ref_clk,
  input logic            rst_n,
  input logic [SF_W-1:0] scale_factor,
  input logic [2:0]      ratio_code,
  input logic            wire3_mode,
  input logic            div_test_en,
  input logic            fp_pulse,
  input logic            fr_pulse,
  input logic            test_pin_fp,
  input logic            test_pin_fr
);

  logic [SF_W-1:0] eff_sf;
  assign eff_sf = wire3_mode ? {1'b0, scale_factor[SF_W-2:0]} : scale_factor;

  p_fp_narrow_r8: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (fp_pulse && eff_sf > 1 && $stable(eff_sf)) |=> !fp_pulse);

  p_fr_narrow_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fr_pulse |=> !fr_pulse);

  p_ref_stop_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!wire3_mode && ratio_code == 3'b001) |=> !fr_pulse);

  p_sf_zero_r3: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (eff_sf == '0) |=> !fp_pulse);

  p_test_quiet_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !div_test_en |-> (!test_pin_fp && !test_pin_fr));

  p_reset_fr_r11: assert property (@(posedge ref_clk)
    !rst_n |=> !fr_pulse);

  p_reset_fp_r11: assert property (@(posedge vco_clk)
    !rst_n |=> !fp_pulse);

endmodule

bind pll_divider_pair pll_divider_pair_chk #(.SF_W(SF_W)) u_pll_divider_pair_chk (
  .vco_clk      (vco_clk),
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .scale_factor (scale_factor),
  .ratio_code   (ratio_code),
  .wire3_mode   (wire3_mode),
  .div_test_en  (div_test_en),
  .fp_pulse     (fp_pulse),
  .fr_pulse     (fr_pulse),
  .test_pin_fp  (test_pin_fp),
  .test_pin_fr  (test_pin_fr)
);

// File: tb/test_pll_divider_pair.sv
module test_pll_divider_pair;

  logic        vco_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic [14:0] scale_factor = 15'd1000;
  logic [2:0]  ratio_code   = 3'd6;
  logic        wire3_mode   = 1'b0;
  logic        ref_bank_hi  = 1'b0;
  logic        div_test_en  = 1'b0;
  logic        fp_pulse, fr_pulse, test_pin_fp, test_pin_fr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 ref_clk = ~ref_clk;   // 50 MHz
  always #2.5 vco_clk = ~vco_clk;

  pll_divider_pair i_pll_divider_pair (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .scale_factor(scale_factor), .ratio_code(ratio_code),
    .wire3_mode(wire3_mode), .ref_bank_hi(ref_bank_hi),
    .div_test_en(div_test_en), .fp_pulse(fp_pulse), .fr_pulse(fr_pulse),
    .test_pin_fp(test_pin_fp), .test_pin_fr(test_pin_fr)
  );

  function automatic int exp_ref(bit tw, bit bank, logic [2:0] code);
    if (!tw) begin
      case (code)
        3'd0: return 1024;  3'd1: return 0;   3'd2: return 256; 3'd3: return 512;
        3'd4: return 140;   3'd5: return 25;  3'd6: return 250; default: return 50;
      endcase
    end
    case ({bank, code[1:0]})
      3'b000: return 280; 3'b001: return 50;  3'b010: return 500; 3'b011: return 100;
      3'b100: return 140; 3'b101: return 25;  3'b110: return 250; default: return 50;
    endcase
  endfunction

  function automatic int exp_sf(bit tw, logic [14:0] sf);
    return tw ? int'(sf & 15'h3FFF) : int'(sf);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input bit on_fr);
    if (on_fr) @(negedge ref_clk);
    else       @(negedge vco_clk);
  endtask

  function automatic bit pulse_of(input bit on_fr);
    return on_fr ? fr_pulse : fp_pulse;
  endfunction

  task automatic next_pulse(input bit on_fr, input int limit, output int span, output bit wide);
    span = 0;
    wide = 1'b0;
    do begin
      tick(on_fr);
      span++;
      if (span == 1 && pulse_of(on_fr)) wide = 1'b1;
    end while (!pulse_of(on_fr) && span < limit);
    if (!pulse_of(on_fr)) span = -1;
  endtask

  task automatic period(input bit on_fr, input string req, input int exp);
    int  span;
    bit  wide;
    next_pulse(on_fr, 40000, span, wide);
    next_pulse(on_fr, 40000, span, wide);
    chk(span == exp, req, span, exp);
    chk(!wide, "R8", int'(wide), 0);
  endtask

  task automatic count_high(input bit on_fr, input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      tick(on_fr);
      if (pulse_of(on_fr)) hits++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int  span, hits, hits2;
    bit  wide;
    void'($urandom(32'd7731));

    // R11: reset state
    repeat (4) @(negedge ref_clk);
    chk({fp_pulse, fr_pulse} == 2'b00, "R11", {fp_pulse, fr_pulse}, 0);
    chk({test_pin_fp, test_pin_fr} == 2'b00, "R11", {test_pin_fp, test_pin_fr}, 0);
    rst_n = 1'b1;

    // R1: factor bounds
    scale_factor = 15'd256;
    period(1'b0, "R1", 256);
    scale_factor = 15'd32767;
    period(1'b0, "R1", 32767);

    // R4 / R5: two-wire reference table
    for (int c = 0; c < 8; c++) begin
      ratio_code = 3'(c);
      if (c == 1) begin
        @(negedge ref_clk);
        count_high(1'b1, 1500, hits);
        chk(hits == 0, "R5", hits, 0);
      end else begin
        period(1'b1, "R4", exp_ref(1'b0, 1'b0, 3'(c)));
      end
    end
    ratio_code = 3'd1;
    repeat (3) @(negedge ref_clk);
    ratio_code = 3'd5;
    period(1'b1, "R5", 25);

    // R6 / R7: three-wire tables, top code bit set to show it is ignored
    wire3_mode = 1'b1;
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 4; c++) begin
        ref_bank_hi = b[0];
        ratio_code  = {1'b1, 2'(c)};
        period(1'b1, b ? "R7" : "R6", exp_ref(1'b1, b[0], ratio_code));
      end
    end

    // R2 / R3: narrow factor and zero factor
    scale_factor = 15'h4000 | 15'd300;
    period(1'b0, "R2", 300);
    scale_factor = 15'h4000;
    @(negedge vco_clk);
    count_high(1'b0, 2000, hits);
    chk(hits == 0, "R3", hits, 0);
    wire3_mode = 1'b0;
    scale_factor = 15'd0;
    @(negedge vco_clk);
    count_high(1'b0, 2000, hits);
    chk(hits == 0, "R3", hits, 0);

    // R9: change just after a reload; running interval keeps the old ratio
    ratio_code = 3'd6;
    next_pulse(1'b1, 2000, span, wide);
    next_pulse(1'b1, 2000, span, wide);
    ratio_code = 3'd7;
    next_pulse(1'b1, 2000, span, wide);
    chk(span == 250, "R9", span, 250);
    next_pulse(1'b1, 2000, span, wide);
    chk(span == 50, "R9", span, 50);
    scale_factor = 15'd1000;
    next_pulse(1'b0, 40000, span, wide);
    next_pulse(1'b0, 40000, span, wide);
    scale_factor = 15'd300;
    next_pulse(1'b0, 40000, span, wide);
    chk(span == 1000, "R9", span, 1000);
    next_pulse(1'b0, 40000, span, wide);
    chk(span == 300, "R9", span, 300);

    // R10: test routing
    hits = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge ref_clk);
      if (test_pin_fr || test_pin_fp) hits++;
    end
    chk(hits == 0, "R10", hits, 0);
    div_test_en = 1'b1;
    hits = 0; hits2 = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge ref_clk);
      if (test_pin_fr) hits++;
      if (fr_pulse) hits2++;
    end
    chk(hits == hits2 && hits > 0, "R10", hits, hits2);
    hits = 0; hits2 = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge vco_clk);
      if (test_pin_fp) hits++;
      if (fp_pulse) hits2++;
    end
    chk(hits == hits2 && hits > 0, "R10", hits, hits2);
    div_test_en = 1'b0;

    // Random mix of modes, codes and factors (R1, R2, R4, R5, R6, R7)
    for (int k = 0; k < 8; k++) begin
      wire3_mode   = 1'($urandom % 2);
      ref_bank_hi  = 1'($urandom % 2);
      ratio_code   = 3'($urandom % 8);
      scale_factor = 15'(256 + ($urandom % 1792)) | (15'($urandom % 2) << 14);
      period(1'b0, wire3_mode ? "R2" : "R1", exp_sf(wire3_mode, scale_factor));
      if (exp_ref(wire3_mode, ref_bank_hi, ratio_code) == 0) begin
        @(negedge ref_clk);
        count_high(1'b1, 2100, hits);
        chk(hits == 0, "R5", hits, 0);
      end else begin
        period(1'b1, wire3_mode ? "R6" : "R4", exp_ref(wire3_mode, ref_bank_hi, ratio_code));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule